// File: doc/BRIEF.md
# Display RAM Address Pointer Generator

This block tracks where the next byte of pixel data lands in a page-organised monochrome display memory of 128 columns by 64 rows. The memory is split into eight pages of eight rows each. A data byte covers one column of one page: its bit i is the pixel on row page·8+i, with bit 0 the topmost row of the page. Each accepted data byte produces one memory write at the current column and page. The column and page pointers then advance by the rule of the selected addressing mode.

Three advance rules are available. In horizontal mode the column runs across a programmable column window and then steps the page. In vertical mode the page runs down a programmable page window and then steps the column. Both of these modes wrap inside their windows. In page mode the column stops at the column end and the page stays where it is. Decoded pointer commands, each an opcode with an argument, set the mode, the window limits and the pointers. A redraw flag tells the display side that memory contents have changed.

Top module: `gram_ptr_gen`

## Requirements
- R1: After reset the mode is page mode, the column window is 0 to 127, the page window is 0 to 7, both pointers are 0, `redraw_o` is 0 and `mem_we_o` is 0.
- R2: A data byte accepted at a clock edge produces, after that same edge, a one-cycle `mem_we_o` pulse. `mem_col_o`/`mem_page_o` carry the pointer values from before the advance, and `mem_pix_o` equals the byte, so that bit i is the pixel on row page·8+i (bit 0 at the top).
- R3: In horizontal mode (mode code 0) a write increments the column. A column at or beyond the column end reloads the column start instead, and the page then increments, or reloads the page start when it is at or beyond the page end.
- R4: In vertical mode (mode code 1) a write increments the page. A page at or beyond the page end reloads the page start instead, and the column then increments, or reloads the column start when it is at or beyond the column end.
- R5: In page mode (mode code 2) a write increments the column only while the column is below the column end, and never changes the page.
- R6: Opcode 0 sets the mode from argument bits 1:0. Mode code 3 is invalid: writes in it still reach memory but leave both pointers unchanged.
- R7: Opcode 1 sets the column start to argument bits 6:0 and also loads the column pointer. Opcode 2 sets the column end to argument bits 6:0.
- R8: Opcode 3 sets the page start to argument bits 2:0 and also loads the page pointer. Opcode 4 sets the page end to argument bits 2:0.
- R9: Opcode 5 loads the page pointer from argument bits 2:0 and leaves the page window unchanged.
- R10: Opcode 6 replaces column pointer bits 3:0 with argument bits 3:0. Opcode 7 replaces column pointer bits 6:4 with argument bits 2:0. Each leaves the other column bits unchanged.
- R11: `redraw_o` is set by every accepted data byte and cleared by `redraw_ack_i`. When both occur in the same cycle the set wins.
- R12: When `cmd_valid_i` and `wr_byte_i` are high in the same cycle, the command is applied and the data byte is dropped: no memory write, no advance, no redraw set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_byte_i | input | 1 | Data byte strobe |
| wr_data_i | input | 8 | Data byte, eight vertically stacked pixels |
| cmd_valid_i | input | 1 | Pointer command strobe |
| cmd_op_i | input | 3 | Pointer command opcode (0..7, see R6 to R10) |
| cmd_arg_i | input | 8 | Pointer command argument |
| redraw_ack_i | input | 1 | Clears the redraw flag |
| mem_we_o | output | 1 | Display memory write enable |
| mem_col_o | output | 7 | Display memory write column |
| mem_page_o | output | 3 | Display memory write page |
| mem_pix_o | output | 8 | Pixel write data, bit i = row page·8+i |
| ptr_col_o | output | 7 | Current column pointer |
| ptr_page_o | output | 3 | Current page pointer |
| redraw_o | output | 1 | Memory contents changed since last acknowledge |

## Verification
On every cycle the assertions check the following. Each accepted byte yields exactly one write pulse and sets the redraw flag. A collided command/write pair produces no pulse. The single-step advances hold in horizontal and vertical mode, page mode keeps the page steady, and the invalid mode freezes the pointers. Wrap targets at window edges depend on programmed limits, so only the bench's scenarios show them. The same holds for nibble-wise column loads, window defaults after reset, and the exact write address and pixel data: the bench compares these with its reference model across directed corner cases and a long random command mix.

// File: rtl/gram_pkg.sv
package gram_pkg;

   typedef enum logic [1:0] {
      AM_HORIZ = 2'd0,
      AM_VERT  = 2'd1,
      AM_PAGE  = 2'd2,
      AM_BAD   = 2'd3
   } addr_mode_e;

   typedef enum logic [2:0] {
      OP_MODE       = 3'd0,
      OP_COL_START  = 3'd1,
      OP_COL_END    = 3'd2,
      OP_PAGE_START = 3'd3,
      OP_PAGE_END   = 3'd4,
      OP_PAGE_SEL   = 3'd5,
      OP_COL_LO     = 3'd6,
      OP_COL_HI     = 3'd7
   } ptr_op_e;

endpackage

// File: rtl/gram_window_regs.sv
module gram_window_regs
   import gram_pkg::*;
#(
   parameter int COL_W  = 7,
   parameter int PAGE_W = 3,
   parameter int ARG_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  ptr_op_e           cmd_op,
   input  logic [ARG_W-1:0]  cmd_arg,
   output addr_mode_e        mode,
   output logic [COL_W-1:0]  col_lo,
   output logic [COL_W-1:0]  col_hi,
   output logic [PAGE_W-1:0] page_lo,
   output logic [PAGE_W-1:0] page_hi
);

   localparam logic [COL_W-1:0]  COL_MAX  = '1;
   localparam logic [PAGE_W-1:0] PAGE_MAX = '1;

   generate
      if (ARG_W > COL_W) begin : g_arg_spare
         logic arg_unused;
         assign arg_unused = ^cmd_arg[ARG_W-1:COL_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode    <= AM_PAGE;
         col_lo  <= '0;
         col_hi  <= COL_MAX;
         page_lo <= '0;
         page_hi <= PAGE_MAX;
      end else if (cmd_valid) begin
         case (cmd_op)
            OP_MODE:       mode    <= addr_mode_e'(cmd_arg[1:0]);
            OP_COL_START:  col_lo  <= cmd_arg[COL_W-1:0];
            OP_COL_END:    col_hi  <= cmd_arg[COL_W-1:0];
            OP_PAGE_START: page_lo <= cmd_arg[PAGE_W-1:0];
            OP_PAGE_END:   page_hi <= cmd_arg[PAGE_W-1:0];
            default: ;
         endcase
      end
   end

   // Window limits move only under a command (R7, R8)
   assert_win_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(col_lo) && $stable(col_hi) &&
                      $stable(page_lo) && $stable(page_hi)));

endmodule

// File: rtl/gram_advance.sv
module gram_advance
   import gram_pkg::*;
#(
   parameter int COL_W  = 7,
   parameter int PAGE_W = 3
) (
   input  addr_mode_e        mode,
   input  logic [COL_W-1:0]  col,
   input  logic [PAGE_W-1:0] page,
   input  logic [COL_W-1:0]  col_lo,
   input  logic [COL_W-1:0]  col_hi,
   input  logic [PAGE_W-1:0] page_lo,
   input  logic [PAGE_W-1:0] page_hi,
   output logic [COL_W-1:0]  nxt_col,
   output logic [PAGE_W-1:0] nxt_page
);

   localparam logic [COL_W-1:0]  COL_ONE  = 1;
   localparam logic [PAGE_W-1:0] PAGE_ONE = 1;

   logic              col_done, page_done;
   logic [COL_W-1:0]  col_step;
   logic [PAGE_W-1:0] page_step;

   assign col_done  = (col >= col_hi);
   assign page_done = (page >= page_hi);
   assign col_step  = col_done  ? col_lo  : (col + COL_ONE);
   assign page_step = page_done ? page_lo : (page + PAGE_ONE);

   always_comb begin
      nxt_col  = col;
      nxt_page = page;
      case (mode)
         AM_HORIZ: begin
            nxt_col = col_step;
            if (col_done) nxt_page = page_step;
         end
         AM_VERT: begin
            nxt_page = page_step;
            if (page_done) nxt_col = col_step;
         end
         AM_PAGE: begin
            if (!col_done) nxt_col = col + COL_ONE;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/gram_wr_stage.sv
module gram_wr_stage #(
   parameter int COL_W   = 7,
   parameter int PAGE_W  = 3,
   parameter int PIX_W   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_acc,
   input  logic [COL_W-1:0]  col,
   input  logic [PAGE_W-1:0] page,
   input  logic [PIX_W-1:0]  pix,
   input  logic              redraw_ack,
   output logic              mem_we,
   output logic [COL_W-1:0]  mem_col,
   output logic [PAGE_W-1:0] mem_page,
   output logic [PIX_W-1:0]  mem_pix,
   output logic              redraw
);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mem_we   <= 1'b0;
               mem_col  <= '0;
               mem_page <= '0;
               mem_pix  <= '0;
            end else begin
               mem_we <= wr_acc;
               if (wr_acc) begin
                  mem_col  <= col;
                  mem_page <= page;
                  mem_pix  <= pix;
               end
            end
         end

         // R2: one pulse per accepted byte, none otherwise
         assert_we_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_acc |=> mem_we);
         assert_we_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_acc |=> !mem_we);
         assert_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_acc |=> (mem_col == $past(col) && mem_page == $past(page)));
      end else begin : g_comb
         assign mem_we   = wr_acc;
         assign mem_col  = col;
         assign mem_page = page;
         assign mem_pix  = pix;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          redraw <= 1'b0;
      else if (wr_acc)     redraw <= 1'b1;
      else if (redraw_ack) redraw <= 1'b0;
   end

   assert_redraw_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> redraw);
   assert_redraw_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (redraw_ack && !wr_acc) |=> !redraw);

endmodule

// File: rtl/gram_ptr_gen.sv
module gram_ptr_gen
   import gram_pkg::*;
#(
   parameter int COL_W   = 7,
   parameter int PAGE_W  = 3,
   parameter int ARG_W   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_byte_i,
   input  logic [7:0]        wr_data_i,
   input  logic              cmd_valid_i,
   input  logic [2:0]        cmd_op_i,
   input  logic [ARG_W-1:0]  cmd_arg_i,
   input  logic              redraw_ack_i,
   output logic              mem_we_o,
   output logic [COL_W-1:0]  mem_col_o,
   output logic [PAGE_W-1:0] mem_page_o,
   output logic [7:0]        mem_pix_o,
   output logic [COL_W-1:0]  ptr_col_o,
   output logic [PAGE_W-1:0] ptr_page_o,
   output logic              redraw_o
);

   localparam int PIX_W   = 8;
   localparam int NIB_W   = 4;
   localparam int HI_W    = COL_W - NIB_W;
   localparam logic [COL_W-1:0]  COL_ONE  = 1;
   localparam logic [PAGE_W-1:0] PAGE_ONE = 1;

   generate
      if (COL_W <= NIB_W) begin : g_bad_col
         $error("COL_W must exceed the 4-bit low nibble");
      end
      if (ARG_W < COL_W) begin : g_bad_arg
         $error("ARG_W must cover the column width");
      end
      if (PAGE_W < 1) begin : g_bad_page
         $error("PAGE_W must be at least 1");
      end
      if (ARG_W > COL_W) begin : g_arg_spare
         logic arg_unused;
         assign arg_unused = ^cmd_arg_i[ARG_W-1:COL_W];
      end
   endgenerate

   ptr_op_e           op;
   addr_mode_e        mode;
   logic [COL_W-1:0]  col_lo, col_hi, col_q, col_nx;
   logic [PAGE_W-1:0] page_lo, page_hi, page_q, page_nx;
   logic              wr_acc;

   assign op     = ptr_op_e'(cmd_op_i);
   assign wr_acc = wr_byte_i && !cmd_valid_i;   // command wins a collision (R12)

   gram_window_regs #(.COL_W(COL_W), .PAGE_W(PAGE_W), .ARG_W(ARG_W)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid_i),
      .cmd_op    (op),
      .cmd_arg   (cmd_arg_i),
      .mode      (mode),
      .col_lo    (col_lo),
      .col_hi    (col_hi),
      .page_lo   (page_lo),
      .page_hi   (page_hi)
   );

   gram_advance #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_adv (
      .mode     (mode),
      .col      (col_q),
      .page     (page_q),
      .col_lo   (col_lo),
      .col_hi   (col_hi),
      .page_lo  (page_lo),
      .page_hi  (page_hi),
      .nxt_col  (col_nx),
      .nxt_page (page_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q  <= '0;
         page_q <= '0;
      end else if (cmd_valid_i) begin
         case (op)
            OP_COL_START:  col_q  <= cmd_arg_i[COL_W-1:0];
            OP_PAGE_START: page_q <= cmd_arg_i[PAGE_W-1:0];
            OP_PAGE_SEL:   page_q <= cmd_arg_i[PAGE_W-1:0];
            OP_COL_LO:     col_q[NIB_W-1:0]     <= cmd_arg_i[NIB_W-1:0];
            OP_COL_HI:     col_q[COL_W-1:NIB_W] <= cmd_arg_i[HI_W-1:0];
            default: ;
         endcase
      end else if (wr_acc) begin
         col_q  <= col_nx;
         page_q <= page_nx;
      end
   end

   gram_wr_stage #(.COL_W(COL_W), .PAGE_W(PAGE_W), .PIX_W(PIX_W), .REG_OUT(REG_OUT)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_acc     (wr_acc),
      .col        (col_q),
      .page       (page_q),
      .pix        (wr_data_i),
      .redraw_ack (redraw_ack_i),
      .mem_we     (mem_we_o),
      .mem_col    (mem_col_o),
      .mem_page   (mem_page_o),
      .mem_pix    (mem_pix_o),
      .redraw     (redraw_o)
   );

   assign ptr_col_o  = col_q;
   assign ptr_page_o = page_q;

   assert_horiz_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && mode == AM_HORIZ && col_q < col_hi)
         |=> (col_q == $past(col_q) + COL_ONE && $stable(page_q)));

   assert_vert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && mode == AM_VERT && page_q < page_hi)
         |=> (page_q == $past(page_q) + PAGE_ONE && $stable(col_q)));

   assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && mode == AM_PAGE) |=> $stable(page_q));

   assert_page_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && mode == AM_PAGE && col_q >= col_hi) |=> $stable(col_q));

   assert_bad_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && mode == AM_BAD) |=> ($stable(col_q) && $stable(page_q)));

   assert_collide_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && op == OP_MODE) |=> ($stable(col_q) && $stable(page_q)));

endmodule

// File: tb/gram_ptr_gen_test.sv
`timescale 1ns/1ps
module gram_ptr_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_byte_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic       cmd_valid_i = 1'b0;
   logic [2:0] cmd_op_i = '0;
   logic [7:0] cmd_arg_i = '0;
   logic       redraw_ack_i = 1'b0;
   logic       mem_we_o;
   logic [6:0] mem_col_o;
   logic [2:0] mem_page_o;
   logic [7:0] mem_pix_o;
   logic [6:0] ptr_col_o;
   logic [2:0] ptr_page_o;
   logic       redraw_o;

   always #2.5 clk = ~clk;

   gram_ptr_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_byte_i(wr_byte_i), .wr_data_i(wr_data_i),
      .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_arg_i(cmd_arg_i),
      .redraw_ack_i(redraw_ack_i), .mem_we_o(mem_we_o), .mem_col_o(mem_col_o),
      .mem_page_o(mem_page_o), .mem_pix_o(mem_pix_o), .ptr_col_o(ptr_col_o),
      .ptr_page_o(ptr_page_o), .redraw_o(redraw_o)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference model state
   int m_mode, m_cs, m_ce, m_ps, m_pe, m_col, m_page;
   bit m_redraw;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic void model_reset();
      m_mode = 2; m_cs = 0; m_ce = 127; m_ps = 0; m_pe = 7;
      m_col = 0; m_page = 0; m_redraw = 1'b0;
   endfunction

   function automatic void model_advance();
      case (m_mode)
         0: begin
            if (m_col >= m_ce) begin
               m_col = m_cs;
               m_page = (m_page >= m_pe) ? m_ps : m_page + 1;
            end else m_col = m_col + 1;
         end
         1: begin
            if (m_page >= m_pe) begin
               m_page = m_ps;
               m_col = (m_col >= m_ce) ? m_cs : m_col + 1;
            end else m_page = m_page + 1;
         end
         2: if (m_col < m_ce) m_col = m_col + 1;
         default: ;
      endcase
   endfunction

   function automatic void model_cmd(input int op, input int arg);
      case (op)
         0: m_mode = arg & 3;
         1: begin m_cs = arg & 8'h7f; m_col = m_cs; end
         2: m_ce = arg & 8'h7f;
         3: begin m_ps = arg & 7; m_page = m_ps; end
         4: m_pe = arg & 7;
         5: m_page = arg & 7;
         6: m_col = (m_col & 8'h70) | (arg & 4'hf);
         default: m_col = (m_col & 4'hf) | ((arg & 7) << 4);
      endcase
   endfunction

   function automatic string op_tag(input int op);
      case (op)
         0: return "R6";
         1, 2: return "R7";
         3, 4: return "R8";
         5: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic string mode_tag(input int md);
      case (md)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         default: return "R6";
      endcase
   endfunction

   // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
   task automatic step(input bit cv, input int op, input int arg, input bit wr,
                       input int data, input bit ack);
      bit acc;
      int e_col, e_page;
      string tag;
      cmd_valid_i  = cv;
      cmd_op_i     = op[2:0];
      cmd_arg_i    = arg[7:0];
      wr_byte_i    = wr;
      wr_data_i    = data[7:0];
      redraw_ack_i = ack;
      @(negedge clk);
      acc = wr && !cv;
      e_col = m_col;
      e_page = m_page;
      tag = cv ? (wr ? "R12" : op_tag(op)) : mode_tag(m_mode);
      if (cv) model_cmd(op, arg);
      else if (acc) model_advance();
      if (acc) m_redraw = 1'b1;
      else if (ack) m_redraw = 1'b0;
      chk(cv && wr ? "R12" : "R2", "mem_we", int'(mem_we_o), int'(acc));
      if (acc) begin
         chk("R2", "mem_col", int'(mem_col_o), e_col);
         chk("R2", "mem_page", int'(mem_page_o), e_page);
         chk("R2", "mem_pix", int'(mem_pix_o), data & 8'hff);
      end
      chk(tag, "ptr_col", int'(ptr_col_o), m_col);
      chk(tag, "ptr_page", int'(ptr_page_o), m_page);
      chk(cv && wr ? "R12" : "R11", "redraw", int'(redraw_o), int'(m_redraw));
      cmd_valid_i = 1'b0; wr_byte_i = 1'b0; redraw_ack_i = 1'b0;
   endtask

   task automatic cmd(input int op, input int arg);
      step(1'b1, op, arg, 1'b0, 0, 1'b0);
   endtask

   task automatic wr(input int data);
      step(1'b0, 0, 0, 1'b1, data, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      model_reset();
      void'($urandom(32'd20240));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      chk("R1", "ptr_col", int'(ptr_col_o), 0);
      chk("R1", "ptr_page", int'(ptr_page_o), 0);
      chk("R1", "mem_we", int'(mem_we_o), 0);
      chk("R1", "redraw", int'(redraw_o), 0);

      // R1/R5/R10: default column end 127, page-mode stop
      cmd(6, 8'h0e);           // low nibble -> col 14
      cmd(7, 8'h07);           // high bits -> col 126
      chk("R10", "nibble col", int'(ptr_col_o), 126);
      wr(8'h81); wr(8'h42); wr(8'h18);
      chk("R1", "page stop at 127", int'(ptr_col_o), 127);
      // R1: default page window 0..7 wraps in horizontal mode
      cmd(0, 0);
      cmd(5, 7);
      wr(8'hff);
      chk("R1", "wrap col", int'(ptr_col_o), 0);
      chk("R1", "wrap page", int'(ptr_page_o), 0);
      // R3: narrow window
      cmd(1, 8'h85);           // masked to 5
      chk("R7", "col start mask", int'(ptr_col_o), 5);
      cmd(2, 6); cmd(3, 8'hf9); cmd(4, 2);
      chk("R8", "page start mask", int'(ptr_page_o), 1);
      for (int i = 0; i < 6; i++) wr(i * 37);
      // R4: vertical window
      cmd(0, 1);
      for (int i = 0; i < 7; i++) wr(i + 1);
      // R6: invalid mode holds
      cmd(0, 8'hfb);
      wr(8'h5a); wr(8'ha5);
      // R12: collision
      step(1'b1, 5, 3, 1'b1, 8'h33, 1'b0);
      // R11: ack clears, set wins over ack
      step(1'b0, 0, 0, 1'b0, 0, 1'b1);
      chk("R11", "redraw cleared", int'(redraw_o), 0);
      step(1'b0, 0, 0, 1'b1, 8'h11, 1'b1);
      chk("R11", "set wins", int'(redraw_o), 1);
      // R9: page select keeps window
      cmd(0, 0); cmd(1, 0); cmd(2, 1); cmd(4, 4); cmd(3, 2); cmd(5, 4);
      wr(1); wr(2);
      chk("R9", "page wrap to start", int'(ptr_page_o), 2);

      for (int n = 0; n < 4000; n++) begin
         int r;
         r = $urandom % 10;
         case (r)
            0, 1, 2, 3: wr($urandom);
            4: cmd($urandom % 8, $urandom);
            5: step(1'b1, $urandom % 8, $urandom, 1'b1, $urandom, $urandom % 2);
            6: step(1'b0, 0, 0, 1'b0, 0, 1'b1);
            7: step(1'b0, 0, 0, 1'b1, $urandom, 1'b1);
            8: cmd(0, $urandom % 4);
            default: step(1'b0, 0, 0, 1'b0, 0, 1'b0);
         endcase
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule